// File: doc/BRIEF.md
# Address Window Decoder

The block holds a small bank of programmable address windows. Each window has an enable, a base, a size mask, a target ID and an attribute byte. A CPU bus address presented on the lookup port is compared against every window in parallel. The block returns whether any window claimed the address. On a hit it also returns the index, target ID and attribute of the winning window.

Window sizes are given as a mask of ones that must start at the least significant bit, in units of 64 KB. An all-zero mask gives the smallest window of 64 KB, and each extra one doubles the size. A mask that is not a contiguous run of ones from bit 0 is illegal. Such a mask raises that window's configuration-error flag and keeps the window from ever matching.

Configuration goes through a single-cycle write port that selects a window and one of its fields. The lookup path is combinational by default. A parameter adds an output register, which adds one cycle of latency.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled, so no lookup hits, and every configuration-error flag reads 0 because the size masks reset to zero.
- R2: An enabled window with a legal mask claims an address when the address bits 31:16 and the window base agree in every bit position where the size mask is 0. Address bits 15:0 never affect the result.
- R3: A size mask of 0x0000 gives a 64 KB window: only addresses whose upper 16 bits equal the base are claimed.
- R4: Each additional one in the mask doubles the window. A mask of 0x00FF claims 16 MB, and 0x07FF claims 128 MB, both starting at the base.
- R5: When a window's mask is not a run of ones starting at bit 0, its bit in `cfg_err` is 1 and the window claims no address. Rewriting a legal mask clears the flag.
- R6: A disabled window claims no address, whatever its base and size.
- R7: When several enabled windows claim the same address, the lowest-numbered one is reported.
- R8: On a miss, `lk_hit` is 0 and `lk_win`, `lk_tgt` and `lk_attr` are all 0.
- R9: With `REG_OUT` set to 1, the lookup outputs reflect the address presented before the previous rising clock edge, which is one cycle of latency. With `REG_OUT` set to 0 they follow the address combinationally.
- R10: A write takes effect at the rising edge where `wr_en` is 1. Field code 0 loads the base from `wr_data[31:16]`. Field code 1 loads the size mask from `wr_data[15:0]`. Field code 2 loads the enable from `wr_data[31]`, the target from `wr_data[11:8]` and the attribute from `wr_data[7:0]`. Field code 3 and window indices of 6 or more change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_win | input | 3 | Window index for the write |
| wr_fld | input | 2 | Field code: 0 base, 1 size, 2 control, 3 none |
| wr_data | input | 32 | Write data, field placement per R10 |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | An enabled legal window claims the address |
| lk_win | output | 3 | Index of the winning window, 0 on a miss |
| lk_tgt | output | 4 | Target ID of the winning window, 0 on a miss |
| lk_attr | output | 8 | Attribute of the winning window, 0 on a miss |
| cfg_err | output | 6 | Per-window illegal-size flag |

## Verification
The hardest case to reach from the ports is an address claimed by two enabled windows at once. Reaching it needs two windows set up with overlapping ranges of different sizes, followed by a lookup inside the overlap. The stimulus sets up that overlap and looks up addresses both inside and outside the smaller window. It then disables the lower-numbered window and checks that the higher-numbered one takes over. A second situation, an illegal mask that later becomes legal, is reached by rewriting only the size field and repeating the same lookup.

// File: rtl/awd_pkg.sv
// Package: shared constants and the field-select encoding for the
// address window decoder. Assumes 64 KB granularity (16 low address bits).
package awd_pkg;
    localparam int GRAN_BITS = 16;

    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_SIZE = 2'd1,
        FLD_CTRL = 2'd2,
        FLD_NONE = 2'd3
    } awd_fld_e;
endpackage

// File: rtl/awd_win_slot.sv
// One window slot: holds the window's registers, checks that the size mask
// is legal and compares a lookup address with the window.
// Assumes: the write data is already decoded into a per-slot strobe and a
// field code. Reset is synchronous and active low.
module awd_win_slot #(
    parameter int ADDR_W = 32,
    parameter int TGT_W  = 4,
    parameter int ATTR_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we,
    input  awd_pkg::awd_fld_e                    fld,
    input  logic [ADDR_W-1:0]                    data,
    input  logic [ADDR_W-1:0]                    addr,
    output logic                                 match,
    output logic                                 bad_size,
    output logic [TGT_W-1:0]                     tgt,
    output logic [ATTR_W-1:0]                    attr
);
    import awd_pkg::*;
    localparam int SIZE_W = ADDR_W - GRAN_BITS;

    logic              en_q;
    logic [SIZE_W-1:0] base_q;
    logic [SIZE_W-1:0] size_q;
    logic [TGT_W-1:0]  tgt_q;
    logic [ATTR_W-1:0] attr_q;
    logic [SIZE_W-1:0] size_inc;
    logic [SIZE_W-1:0] diff;

    // Purpose: load the selected field on a write, clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            base_q <= '0;
            size_q <= '0;
            tgt_q  <= '0;
            attr_q <= '0;
        end else if (we) begin
            case (fld)
                FLD_BASE: base_q <= data[ADDR_W-1:GRAN_BITS];
                FLD_SIZE: size_q <= data[SIZE_W-1:0];
                FLD_CTRL: begin
                    en_q   <= data[ADDR_W-1];
                    tgt_q  <= data[8 +: TGT_W];
                    attr_q <= data[ATTR_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // Purpose: a legal mask is a run of ones from bit 0, so adding one
    // clears every set bit.
    always_comb begin
        size_inc = size_q + SIZE_W'(1);
        bad_size = (size_q & size_inc) != '0;
    end

    // Purpose: compare the upper address bits outside the mask with the base.
    always_comb begin
        diff  = (addr[ADDR_W-1:GRAN_BITS] ^ base_q) & ~size_q;
        match = en_q && !bad_size && (diff == '0);
    end

    assign tgt  = tgt_q;
    assign attr = attr_q;

    // R5: an illegal size never matches
    a_r5_bad_size_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        bad_size |-> !match);
    // R6: a disabled window never matches
    a_r6_disabled_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !match);
    // R10: a size write lands the next cycle
    a_r10_size_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && fld == FLD_SIZE) |=> size_q == $past(data[SIZE_W-1:0]));
    // R1: reset leaves the window disabled
    a_r1_reset_disabled: assert property (@(posedge clk)
        !rst_n |=> !en_q);
endmodule

// File: rtl/awd_prio_sel.sv
// Priority selector: picks the lowest-numbered matching window and gates
// its target and attribute onto the result. Outputs are zero on a miss.
// Assumes: purely combinational; match vector and field arrays are aligned.
module awd_prio_sel #(
    parameter int NUM_WIN = 6,
    parameter int TGT_W   = 4,
    parameter int ATTR_W  = 8,
    parameter int IDX_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_WIN-1:0]  match,
    input  logic [TGT_W-1:0]    tgt  [NUM_WIN],
    input  logic [ATTR_W-1:0]   attr [NUM_WIN],
    output logic                hit,
    output logic [IDX_W-1:0]    win,
    output logic [TGT_W-1:0]    sel_tgt,
    output logic [ATTR_W-1:0]   sel_attr
);
    // Purpose: scan from the top down so the lowest match is written last.
    always_comb begin
        hit      = 1'b0;
        win      = '0;
        sel_tgt  = '0;
        sel_attr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                win      = IDX_W'(i);
                sel_tgt  = tgt[i];
                sel_attr = attr[i];
            end
        end
    end

    // R7: the reported window really matches
    a_r7_win_matches: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match[win]);

    for (genvar j = 0; j < NUM_WIN; j++) begin : g_lower
        // R7: no lower-numbered window matched
        a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && win > IDX_W'(j)) |-> !match[j]);
    end

    // R8: a miss reports all zeros
    a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (win == '0 && sel_tgt == '0 && sel_attr == '0));
endmodule

// File: rtl/addr_window_decoder.sv
// Top: a bank of NUM_WIN programmable address windows with a register
// write port and a lookup port. Optional output register (REG_OUT).
// Assumes: single clock domain, synchronous active-low reset.
module addr_window_decoder #(
    parameter int NUM_WIN = 6,
    parameter int ADDR_W  = 32,
    parameter int TGT_W   = 4,
    parameter int ATTR_W  = 8,
    parameter bit REG_OUT = 1'b0,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_win,
    input  logic [1:0]         wr_fld,
    input  logic [ADDR_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  lk_addr,
    output logic               lk_hit,
    output logic [IDX_W-1:0]   lk_win,
    output logic [TGT_W-1:0]   lk_tgt,
    output logic [ATTR_W-1:0]  lk_attr,
    output logic [NUM_WIN-1:0] cfg_err
);
    import awd_pkg::*;

    logic [NUM_WIN-1:0] match;
    logic [TGT_W-1:0]   tgt_a  [NUM_WIN];
    logic [ATTR_W-1:0]  attr_a [NUM_WIN];
    logic               hit_c;
    logic [IDX_W-1:0]   win_c;
    logic [TGT_W-1:0]   tgt_c;
    logic [ATTR_W-1:0]  attr_c;
    awd_fld_e           fld;

    assign fld = awd_fld_e'(wr_fld);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        logic we_i;
        // Purpose: decode the write strobe for this slot.
        assign we_i = wr_en && (wr_win == IDX_W'(i));

        awd_win_slot #(
            .ADDR_W (ADDR_W),
            .TGT_W  (TGT_W),
            .ATTR_W (ATTR_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (we_i),
            .fld      (fld),
            .data     (wr_data),
            .addr     (lk_addr),
            .match    (match[i]),
            .bad_size (cfg_err[i]),
            .tgt      (tgt_a[i]),
            .attr     (attr_a[i])
        );
    end

    awd_prio_sel #(
        .NUM_WIN (NUM_WIN),
        .TGT_W   (TGT_W),
        .ATTR_W  (ATTR_W),
        .IDX_W   (IDX_W)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .tgt      (tgt_a),
        .attr     (attr_a),
        .hit      (hit_c),
        .win      (win_c),
        .sel_tgt  (tgt_c),
        .sel_attr (attr_c)
    );

    if (REG_OUT) begin : g_reg
        // Purpose: register the lookup result for one cycle of latency.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lk_hit  <= 1'b0;
                lk_win  <= '0;
                lk_tgt  <= '0;
                lk_attr <= '0;
            end else begin
                lk_hit  <= hit_c;
                lk_win  <= win_c;
                lk_tgt  <= tgt_c;
                lk_attr <= attr_c;
            end
        end

        // R9: registered outputs trail the combinational result by one cycle
        a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (lk_hit == $past(hit_c) && lk_win == $past(win_c)));
    end else begin : g_comb
        // Purpose: pass the lookup result straight through.
        assign lk_hit  = hit_c;
        assign lk_win  = win_c;
        assign lk_tgt  = tgt_c;
        assign lk_attr = attr_c;
    end

    // R1: the cycle after reset nothing hits
    a_r1_no_hit_after_reset: assert property (@(posedge clk)
        !rst_n |=> !hit_c);
endmodule

// File: tb/addr_window_decoder_test.sv
module addr_window_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_win = '0;
    logic [1:0]  wr_fld = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] lk_addr = '0;
    logic        hit, hit_r;
    logic [2:0]  win, win_r;
    logic [3:0]  tgt, tgt_r;
    logic [7:0]  attr, attr_r;
    logic [5:0]  cerr, cerr_r;
    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    addr_window_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win),
        .wr_fld(wr_fld), .wr_data(wr_data), .lk_addr(lk_addr),
        .lk_hit(hit), .lk_win(win), .lk_tgt(tgt), .lk_attr(attr),
        .cfg_err(cerr));

    addr_window_decoder #(.REG_OUT(1'b1)) uut_r (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win),
        .wr_fld(wr_fld), .wr_data(wr_data), .lk_addr(lk_addr),
        .lk_hit(hit_r), .lk_win(win_r), .lk_tgt(tgt_r), .lk_attr(attr_r),
        .cfg_err(cerr_r));

    // Vector: {addr[31:0], hit, win[2:0], tgt[3:0], attr[7:0]}
    localparam int NV = 11;
    localparam logic [47:0] VEC [NV] = '{
        {32'h9000_0000, 1'b1, 3'd0, 4'd4, 8'hE8},  // R4 16 MB start
        {32'h90FF_FFFF, 1'b1, 3'd0, 4'd4, 8'hE8},  // R4 16 MB end
        {32'h9100_0000, 1'b0, 3'd0, 4'd0, 8'h00},  // R4 past end
        {32'hF000_ABCD, 1'b1, 3'd1, 4'd1, 8'h2F},  // R3 64 KB, low bits ignored (R2)
        {32'hF001_0000, 1'b0, 3'd0, 4'd0, 8'h00},  // R3 next 64 KB
        {32'hEFFF_FFFF, 1'b0, 3'd0, 4'd0, 8'h00},  // R8 below window
        {32'hD800_0000, 1'b1, 3'd2, 4'd1, 8'h1E},  // R7 overlap, lowest wins
        {32'hDFFF_FFFC, 1'b1, 3'd2, 4'd1, 8'h1E},  // R4 128 MB end
        {32'hD7FF_FFFF, 1'b0, 3'd0, 4'd0, 8'h00},  // R2 below base
        {32'hE000_1234, 1'b0, 3'd0, 4'd0, 8'h00},  // R5 illegal size
        {32'hC800_0010, 1'b0, 3'd0, 4'd0, 8'h00}   // R6 disabled
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int w, input int f, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_win = 3'(w); wr_fld = 2'(f); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input string req, input logic [31:0] a, input logic [15:0] exp);
        lk_addr = a;
        #1;
        check(req, {16'h0, hit, win, tgt, attr}, {16'h0, exp});
    endtask

    task automatic setw(input int w, input logic [15:0] b, input logic [15:0] s,
                        input logic en, input logic [3:0] t, input logic [7:0] at);
        wr(w, 0, {b, 16'h0});
        wr(w, 1, {16'h0, s});
        wr(w, 2, {en, 19'h0, t, at});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 hit after reset", {31'h0, hit}, 32'h0);
        check("R1 cfg_err after reset", {26'h0, cerr}, 32'h0);
        look("R1 addr 0 misses", 32'h0000_0000, 16'h0);

        setw(0, 16'h9000, 16'h00FF, 1'b1, 4'd4, 8'hE8);
        setw(1, 16'hF000, 16'h0000, 1'b1, 4'd1, 8'h2F);
        setw(2, 16'hD800, 16'h07FF, 1'b1, 4'd1, 8'h1E);
        setw(3, 16'hD800, 16'h00FF, 1'b1, 4'd2, 8'h2D);
        setw(4, 16'hE000, 16'h0005, 1'b1, 4'd3, 8'h11);
        setw(5, 16'hC800, 16'h0000, 1'b0, 4'd5, 8'h01);
        @(negedge clk);
        check("R5 cfg_err only window 4", {26'h0, cerr}, 32'h10);

        for (int i = 0; i < NV; i++)
            look("R2 vector table", VEC[i][47:16], VEC[i][15:0]);

        // R6: enabling window 5 makes it claim its range
        wr(5, 2, {1'b1, 19'h0, 4'd5, 8'h01});
        look("R6 enabled window 5", 32'hC800_0010, {1'b1, 3'd5, 4'd5, 8'h01});

        // R5: rewrite a legal size (256 KB) and the flag clears
        wr(4, 1, 32'h0000_0003);
        #1;
        check("R5 cfg_err cleared", {26'h0, cerr}, 32'h0);
        look("R5 legal now hits", 32'hE003_0000, {1'b1, 3'd4, 4'd3, 8'h11});
        look("R4 256 KB end", 32'hE004_0000, 16'h0);

        // R7: disable window 2, window 3 takes the overlap
        wr(2, 2, {1'b0, 19'h0, 4'd1, 8'h1E});
        look("R7 higher window takes over", 32'hD800_0000, {1'b1, 3'd3, 4'd2, 8'h2D});
        look("R6 disabled 128 MB part", 32'hD900_0000, 16'h0);

        // R10: field code 3 and out-of-range index change nothing
        wr(0, 3, 32'h0000_0000);
        wr(6, 2, 32'h0000_0000);
        wr(7, 1, 32'h0000_0005);
        look("R10 ignored writes", 32'h9000_0000, {1'b1, 3'd0, 4'd4, 8'hE8});
        check("R10 no new cfg_err", {26'h0, cerr}, 32'h0);

        // R4: full mask covers the whole space
        wr(1, 1, 32'h0000_FFFF);
        look("R4 full mask", 32'h1234_5678, {1'b1, 3'd1, 4'd1, 8'h2F});
        wr(1, 1, 32'h0000_0000);

        // R9: registered instance trails by one cycle
        @(negedge clk);
        lk_addr = 32'h9000_0000;
        @(negedge clk);
        check("R9 registered hit", {16'h0, hit_r, win_r, tgt_r, attr_r},
              {16'h0, 1'b1, 3'd0, 4'd4, 8'hE8});
        lk_addr = 32'h9100_0000;
        #1;
        check("R9 old value held", {31'h0, hit_r}, 32'h1);
        check("R9 comb follows at once", {31'h0, hit}, 32'h0);
        @(negedge clk);
        check("R9 registered miss", {16'h0, hit_r, win_r, tgt_r, attr_r}, 32'h0);

        // R1: reset again clears all windows
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look("R1 reset disables windows", 32'h9000_0000, 16'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule